// File: doc/BRIEF.md
# ASID-Tagged TLB Lookup

A small fully associative translation buffer for 4 KB pages. It takes a virtual address, the 2-bit privilege ring and the kind of an access. It returns the physical address, a cacheability attribute and a set of status flags: hit, miss, multi-hit and permission fault. The ring does not select an address space directly. Instead it picks an 8-bit ASID out of a ring-to-ASID map word, and only entries tagged with that ASID can match. Ring 0 is hard-wired to ASID 1. An ASID of zero in an entry marks it as dead.

The storage has two parts. The refillable part (16 entries by default) is written by a refill engine through a fill strobe, and the victim entry is chosen in round-robin order. Beside it sit three pinned entries that only explicit software writes can load, so refill never displaces them. Any single entry can be cleared through an invalidate port. Lookup is purely combinational. All writes land on the next rising clock edge.

Top module: `asid_tlb`

## Requirements
- R1: After synchronous reset every entry is dead, so every lookup reports a miss, with a physical address of zero and cacheability low.
- R2: A lookup that matches exactly one live entry raises hit in the same cycle. The physical address is the entry's frame number placed above the 12 untranslated offset bits of the virtual address, and cacheability is the entry's attribute. When there is no hit the address and cacheability outputs are zero.
- R3: For ring r = 1, 2, 3 the lookup ASID is bits [8r+7:8r] of the map word. Ring 0 always uses ASID 1, whatever bits [7:0] hold.
- R4: An entry whose ASID is 0 never matches, even when the lookup ASID taken from the map is also 0.
- R5: If two or more live entries match, refillable or pinned, multi-hit is raised while hit and miss stay low. The address, cacheability and permission fault outputs are then all zero.
- R6: Access kind encoding is 0 = load, 1 = store, 2 = fetch, 3 = load. On a hit, a store to an entry without write enable or a fetch from an entry without execute enable raises permission fault, and the address is still produced. Loads never fault.
- R7: Each fill strobe writes the refillable entry under the round-robin pointer and advances it. The k-th fill after reset (counting from 0) lands in slot k mod 16, so the 17th fill overwrites the first.
- R8: A pinned write with way 0 to 2 loads that pinned entry. Refill never overwrites a pinned entry, and a pinned write with way 3 changes nothing.
- R9: An invalidate with index 0 to 15 kills that refillable slot, and index 16 to 18 kills pinned way index-16. Indices of 19 and above have no effect. If an invalidate and a write reach the same entry in one cycle, the invalidate wins.
- R10: A fill, pinned write or invalidate is not visible to a lookup in the cycle it is presented, and is visible from the next rising edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_ring | input | 2 | Privilege ring of the access |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| ring_asid_map | input | 32 | Four 8-bit ASID fields, one per ring |
| lk_hit | output | 1 | Exactly one live entry matched |
| lk_miss | output | 1 | No live entry matched |
| lk_multi | output | 1 | More than one live entry matched |
| lk_perm_fault | output | 1 | Hit entry forbids the access kind |
| lk_cacheable | output | 1 | Cacheability attribute of the hit entry |
| lk_paddr | output | 32 | Translated physical address |
| wr_vpn | input | 20 | Virtual page number for a fill or pinned write |
| wr_asid | input | 8 | ASID for a fill or pinned write |
| wr_pfn | input | 20 | Physical frame number for a fill or pinned write |
| wr_write | input | 1 | Write enable bit of the new entry |
| wr_exec | input | 1 | Execute enable bit of the new entry |
| wr_cache | input | 1 | Cacheability attribute of the new entry |
| fill_en | input | 1 | Refill strobe, writes the round-robin victim |
| pin_en | input | 1 | Pinned write strobe |
| pin_way | input | 2 | Pinned way selected by a pinned write |
| inv_en | input | 1 | Invalidate strobe |
| inv_idx | input | 5 | Entry index to invalidate |

## Verification
The assertions assume that the lookup inputs and the strobes hold known values once reset has been released, and that the round-robin pointer moves only on a fill strobe. The bench drives every input from a defined value at time zero. It changes inputs only on falling edges and reads the combinational lookup a short time later, so each lookup sees a stable table. Each strobe is raised for exactly one cycle, and the strobes are never combined in a way the stated precedence does not cover.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int PFN_W     = PA_W - PAGE_BITS;
    localparam int ASID_W    = 8;
    localparam int RINGS     = 4;
    localparam int MAP_W     = RINGS * ASID_W;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_LOAD2 = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic              wr;
        logic              ex;
        logic              ca;
    } tlb_ent_t;

    // Ring 0 is fixed to the kernel ASID; other rings read their map field.
    function automatic logic [ASID_W-1:0] ring_asid(input logic [1:0] ring,
                                                    input logic [MAP_W-1:0] map);
        if (ring == 2'd0)
            return ASID_W'(1);
        return map[ring*ASID_W +: ASID_W];
    endfunction

    function automatic logic perm_ok(input tlb_ent_t e, input acc_kind_e k);
        case (k)
            ACC_STORE: return e.wr;
            ACC_FETCH: return e.ex;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
    import tlb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     ld,
    input  tlb_ent_t ld_data,
    output tlb_ent_t ent
);
    always_ff @(posedge clk) begin
        if (rst)
            ent <= '0;
        else if (clr)
            ent.asid <= '0;
        else if (ld)
            ent <= ld_data;
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter  int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [IW-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (adv)
            idx <= (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter  int N_ENT = 19,
    localparam int CW    = $clog2(N_ENT + 1)
) (
    input  tlb_ent_t [N_ENT-1:0] ents,
    input  logic [VPN_W-1:0]     vpn,
    input  logic [ASID_W-1:0]    asid,
    output logic [N_ENT-1:0]     hits,
    output logic [CW-1:0]        n_hits,
    output tlb_ent_t             sel
);
    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign hits[i] = (ents[i].asid != '0) && (ents[i].asid == asid)
                         && (ents[i].vpn == vpn);
    end

    always_comb begin
        n_hits = '0;
        sel    = '0;
        for (int i = 0; i < N_ENT; i++) begin
            n_hits = n_hits + CW'(hits[i]);
            sel    = tlb_ent_t'(sel | ({$bits(tlb_ent_t){hits[i]}} & ents[i]));
        end
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter  int N_REFILL = 16,
    parameter  int N_PINNED = 3,
    localparam int N_ENT    = N_REFILL + N_PINNED,
    localparam int IDX_W    = $clog2(N_ENT),
    localparam int PW       = (N_PINNED > 1) ? $clog2(N_PINNED + 1) : 1,
    localparam int VW       = (N_REFILL > 1) ? $clog2(N_REFILL) : 1,
    localparam int CW       = $clog2(N_ENT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [1:0]        lk_ring,
    input  logic [1:0]        lk_kind,
    input  logic [MAP_W-1:0]  ring_asid_map,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_multi,
    output logic              lk_perm_fault,
    output logic              lk_cacheable,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_write,
    input  logic              wr_exec,
    input  logic              wr_cache,
    input  logic              fill_en,
    input  logic              pin_en,
    input  logic [PW-1:0]     pin_way,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx
);
    tlb_ent_t [N_ENT-1:0] ents;
    tlb_ent_t             new_ent;
    tlb_ent_t             sel;
    logic [N_ENT-1:0]     hits;
    logic [CW-1:0]        n_hits;
    logic [VW-1:0]        victim_idx;
    logic [ASID_W-1:0]    cur_asid;

    assign new_ent = '{vpn: wr_vpn, asid: wr_asid, pfn: wr_pfn,
                       wr: wr_write, ex: wr_exec, ca: wr_cache};

    tlb_victim #(.N(N_REFILL)) u_victim (
        .clk (clk),
        .rst (rst),
        .adv (fill_en),
        .idx (victim_idx)
    );

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        logic clr_i, ld_i;
        assign clr_i = inv_en && (inv_idx == IDX_W'(i));
        if (i < N_REFILL) begin : g_refill
            assign ld_i = fill_en && (victim_idx == VW'(i));
        end else begin : g_pinned
            assign ld_i = pin_en && (pin_way == PW'(i - N_REFILL));
        end
        tlb_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr_i),
            .ld      (ld_i),
            .ld_data (new_ent),
            .ent     (ents[i])
        );
    end

    assign cur_asid = ring_asid(lk_ring, ring_asid_map);

    tlb_match #(.N_ENT(N_ENT)) u_match (
        .ents   (ents),
        .vpn    (lk_vaddr[VA_W-1:PAGE_BITS]),
        .asid   (cur_asid),
        .hits   (hits),
        .n_hits (n_hits),
        .sel    (sel)
    );

    always_comb begin
        lk_hit        = (n_hits == CW'(1));
        lk_miss       = (n_hits == '0);
        lk_multi      = !lk_hit && !lk_miss;
        lk_paddr      = lk_hit ? {sel.pfn, lk_vaddr[PAGE_BITS-1:0]} : '0;
        lk_cacheable  = lk_hit && sel.ca;
        lk_perm_fault = lk_hit && !perm_ok(sel, acc_kind_e'(lk_kind));
    end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
    import tlb_pkg::*;
#(
    parameter  int N_REFILL = 16,
    localparam int VW       = (N_REFILL > 1) ? $clog2(N_REFILL) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic [VA_W-1:0] lk_vaddr,
    input logic [1:0]      lk_kind,
    input logic            lk_hit,
    input logic            lk_miss,
    input logic            lk_multi,
    input logic            lk_perm_fault,
    input logic            lk_cacheable,
    input logic [PA_W-1:0] lk_paddr,
    input logic            fill_en,
    input logic [VW-1:0]   victim
);
    // R1
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> (lk_miss && !lk_hit && !lk_multi));

    // R5
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({lk_hit, lk_miss, lk_multi}));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]));

    // R2
    nohit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_paddr == '0 && !lk_cacheable));

    // R6
    load_nofault_chk: assert property (@(posedge clk) disable iff (rst)
        lk_perm_fault |-> (lk_hit && (lk_kind == 2'd1 || lk_kind == 2'd2)));

    // R7
    victim_step_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (victim == (($past(victim) == VW'(N_REFILL - 1)) ?
                                '0 : $past(victim) + 1'b1)));

    // R7
    victim_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fill_en |=> $stable(victim));
endmodule

bind asid_tlb tlb_chk #(.N_REFILL(N_REFILL)) u_tlb_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_vaddr      (lk_vaddr),
    .lk_kind       (lk_kind),
    .lk_hit        (lk_hit),
    .lk_miss       (lk_miss),
    .lk_multi      (lk_multi),
    .lk_perm_fault (lk_perm_fault),
    .lk_cacheable  (lk_cacheable),
    .lk_paddr      (lk_paddr),
    .fill_en       (fill_en),
    .victim        (victim_idx)
);

// File: tb/test_asid_tlb.sv
module test_asid_tlb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_ring = '0;
    logic [1:0]  lk_kind = '0;
    logic [31:0] ring_asid_map = 32'h3020_10EE;
    logic        lk_hit, lk_miss, lk_multi, lk_perm_fault, lk_cacheable;
    logic [31:0] lk_paddr;
    logic [19:0] wr_vpn = '0;
    logic [7:0]  wr_asid = '0;
    logic [19:0] wr_pfn = '0;
    logic        wr_write = 1'b0, wr_exec = 1'b0, wr_cache = 1'b0;
    logic        fill_en = 1'b0, pin_en = 1'b0, inv_en = 1'b0;
    logic [1:0]  pin_way = '0;
    logic [4:0]  inv_idx = '0;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    asid_tlb i_asid_tlb (.*);

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  ring;
        logic [1:0]  kind;
        logic        hit, miss, multi, fault, ca;
        logic [31:0] pa;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0001_0ABC, 2'd0, 2'd0, 1'b1,1'b0,1'b0,1'b0,1'b1, 32'h0A00_0ABC, 4'd2}, // R2
        '{32'h0001_0123, 2'd0, 2'd1, 1'b1,1'b0,1'b0,1'b0,1'b1, 32'h0A00_0123, 4'd6}, // R6
        '{32'h0001_0123, 2'd1, 2'd0, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0,         4'd3}, // R3
        '{32'h0002_0FFF, 2'd1, 2'd2, 1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0B00_0FFF, 4'd3}, // R3
        '{32'h0002_0000, 2'd1, 2'd1, 1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0B00_0000, 4'd6}, // R6
        '{32'h0002_0000, 2'd0, 2'd0, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0,         4'd3}, // R3
        '{32'h0003_0456, 2'd2, 2'd2, 1'b1,1'b0,1'b0,1'b1,1'b1, 32'h0C00_0456, 4'd6}, // R6
        '{32'h0003_0456, 2'd2, 2'd3, 1'b1,1'b0,1'b0,1'b0,1'b1, 32'h0C00_0456, 4'd6}, // R6
        '{32'h0004_0000, 2'd0, 2'd0, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0,         4'd4}, // R4
        '{32'h0005_0000, 2'd3, 2'd0, 1'b0,1'b0,1'b1,1'b0,1'b0, 32'h0,         4'd5}, // R5
        '{32'h0006_0ABC, 2'd0, 2'd1, 1'b1,1'b0,1'b0,1'b1,1'b1, 32'h1100_0ABC, 4'd8}, // R8
        '{32'h0006_0ABC, 2'd0, 2'd2, 1'b1,1'b0,1'b0,1'b0,1'b1, 32'h1100_0ABC, 4'd8}, // R8
        '{32'h0007_0000, 2'd0, 2'd0, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0,         4'd2}, // R2
        '{32'h0005_0000, 2'd2, 2'd0, 1'b0,1'b1,1'b0,1'b0,1'b0, 32'h0,         4'd3}  // R3
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    // Applies a lookup between clock edges and compares every output.
    task automatic check_lu(input logic [31:0] va, input logic [1:0] ring,
                            input logic [1:0] kind, input logic [36:0] exp,
                            input string tag);
        logic [36:0] act;
        lk_vaddr = va;
        lk_ring  = ring;
        lk_kind  = kind;
        #2;
        act = {lk_hit, lk_miss, lk_multi, lk_perm_fault, lk_cacheable, lk_paddr};
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s va=%h ring=%0d kind=%0d actual=%h expected=%h",
                     tag, va, ring, kind, act, exp);
        end
    endtask

    function automatic logic [36:0] hit_exp(input logic fault, input logic ca,
                                            input logic [31:0] pa);
        return {1'b1, 1'b0, 1'b0, fault, ca, pa};
    endfunction

    localparam logic [36:0] MISS  = {1'b0, 1'b1, 1'b0, 2'b00, 32'h0};
    localparam logic [36:0] MULTI = {1'b0, 1'b0, 1'b1, 2'b00, 32'h0};

    task automatic set_wr(input logic [19:0] vpn, input logic [7:0] asid,
                          input logic [19:0] pfn, input logic w, x, c);
        wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
        wr_write = w; wr_exec = x; wr_cache = c;
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [7:0] asid,
                           input logic [19:0] pfn, input logic w, x, c);
        @(negedge clk);
        set_wr(vpn, asid, pfn, w, x, c);
        fill_en = 1'b1;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_pin(input logic [1:0] way, input logic [19:0] vpn,
                          input logic [7:0] asid, input logic [19:0] pfn,
                          input logic w, x, c);
        @(negedge clk);
        set_wr(vpn, asid, pfn, w, x, c);
        pin_way = way;
        pin_en  = 1'b1;
        @(negedge clk);
        pin_en = 1'b0;
    endtask

    task automatic do_inv(input logic [4:0] idx);
        @(negedge clk);
        inv_idx = idx;
        inv_en  = 1'b1;
        @(negedge clk);
        inv_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: empty table after reset
        check_lu(32'h0001_0000, 2'd0, 2'd0, MISS, "R1");
        check_lu(32'h0000_0000, 2'd3, 2'd2, MISS, "R1");

        // R10: fill invisible in its own cycle, visible after the edge
        @(negedge clk);
        set_wr(20'h00010, 8'h01, 20'h0A000, 1'b1, 1'b1, 1'b1);
        fill_en = 1'b1;
        check_lu(32'h0001_0ABC, 2'd0, 2'd0, MISS, "R10");
        @(negedge clk);
        fill_en = 1'b0;
        check_lu(32'h0001_0ABC, 2'd0, 2'd0, hit_exp(1'b0, 1'b1, 32'h0A00_0ABC), "R10");

        // Remaining setup: slots 1..5, pinned ways 0 and 1
        do_fill(20'h00020, 8'h10, 20'h0B000, 1'b0, 1'b1, 1'b0);
        do_fill(20'h00030, 8'h20, 20'h0C000, 1'b1, 1'b0, 1'b1);
        do_fill(20'h00040, 8'h00, 20'h0D000, 1'b1, 1'b1, 1'b1);
        do_fill(20'h00050, 8'h30, 20'h0E000, 1'b1, 1'b1, 1'b0);
        do_fill(20'h00050, 8'h30, 20'h0F000, 1'b1, 1'b1, 1'b0);
        do_pin(2'd0, 20'h00060, 8'h01, 20'h11000, 1'b0, 1'b1, 1'b1);
        do_pin(2'd1, 20'h00020, 8'hEE, 20'h12000, 1'b1, 1'b1, 1'b1);

        @(negedge clk);
        for (int i = 0; i < NV; i++)
            check_lu(VECS[i].va, VECS[i].ring, VECS[i].kind,
                     {VECS[i].hit, VECS[i].miss, VECS[i].multi, VECS[i].fault,
                      VECS[i].ca, VECS[i].pa},
                     $sformatf("R%0d", VECS[i].req));

        // R4: a zero lookup ASID must not wake a dead entry
        ring_asid_map = 32'h3020_00EE;
        check_lu(32'h0004_0000, 2'd1, 2'd0, MISS, "R4");
        check_lu(32'h0002_0000, 2'd1, 2'd0, MISS, "R4");
        ring_asid_map = 32'h3020_10EE;

        // R7: slots 6..15, then wrap to slot 0
        for (int k = 0; k < 10; k++)
            do_fill(20'h00100 + 20'(k), 8'h01, 20'h20000 + 20'(k), 1'b1, 1'b1, 1'b0);
        do_fill(20'h00200, 8'h01, 20'h30000, 1'b1, 1'b1, 1'b0);
        check_lu(32'h0001_0000, 2'd0, 2'd0, MISS, "R7");
        check_lu(32'h0020_0000, 2'd0, 2'd0, hit_exp(1'b0, 1'b0, 32'h3000_0000), "R7");
        check_lu(32'h0010_9000, 2'd0, 2'd0, hit_exp(1'b0, 1'b0, 32'h2000_9000), "R7");
        // R8: pinned entry survives a full refill lap
        check_lu(32'h0006_0000, 2'd0, 2'd0, hit_exp(1'b0, 1'b1, 32'h1100_0000), "R8");
        do_fill(20'h00210, 8'h10, 20'h31000, 1'b1, 1'b1, 1'b1);
        check_lu(32'h0002_0000, 2'd1, 2'd0, MISS, "R7");
        check_lu(32'h0021_0000, 2'd1, 2'd0, hit_exp(1'b0, 1'b1, 32'h3100_0000), "R7");

        // R8: pinned way 3 does not exist
        do_pin(2'd3, 20'h00300, 8'h01, 20'h33000, 1'b1, 1'b1, 1'b1);
        check_lu(32'h0030_0000, 2'd0, 2'd0, MISS, "R8");

        // R5: pinned and refillable entries colliding
        do_pin(2'd2, 20'h00200, 8'h01, 20'h32000, 1'b1, 1'b1, 1'b1);
        check_lu(32'h0020_0000, 2'd0, 2'd1, MULTI, "R5");

        // R9: invalidates
        do_inv(5'd18);
        check_lu(32'h0020_0000, 2'd0, 2'd0, hit_exp(1'b0, 1'b0, 32'h3000_0000), "R9");
        do_inv(5'd16);
        check_lu(32'h0006_0000, 2'd0, 2'd0, MISS, "R9");
        do_inv(5'd31);
        check_lu(32'h0021_0000, 2'd1, 2'd0, hit_exp(1'b0, 1'b1, 32'h3100_0000), "R9");
        do_inv(5'd0);
        check_lu(32'h0020_0000, 2'd0, 2'd0, MISS, "R9");

        // R9: invalidate beats a pinned write to the same entry
        @(negedge clk);
        set_wr(20'h00400, 8'h01, 20'h34000, 1'b1, 1'b1, 1'b1);
        pin_way = 2'd1; pin_en = 1'b1;
        inv_idx = 5'd17; inv_en = 1'b1;
        @(negedge clk);
        pin_en = 1'b0; inv_en = 1'b0;
        check_lu(32'h0040_0000, 2'd0, 2'd0, MISS, "R9");

        // R1: reset clears a populated table
        do_reset();
        check_lu(32'h0010_9000, 2'd0, 2'd0, MISS, "R1");
        check_lu(32'h0021_0000, 2'd1, 2'd0, MISS, "R1");

        finish_run();
    end

endmodule